// File: doc/BRIEF.md
# Montgomery Modular Multiplier

This block multiplies two residues modulo an odd modulus and returns the product scaled by the inverse of a power-of-two radix: result = A·B·2^(−K) mod N. It uses no divider. The reduction works from a precomputed negative inverse of the modulus. The block keeps only the low K bits of one intermediate value and drops the low K bits of another, so the reduction costs two further integer multiplications, one addition and one conditional subtraction.

All three integer products go through a single one-level Karatsuba multiplier, used once per step. These are the operand product, the reduction factor and the factor times the modulus. A small sequencer steps the datapath through the phases of one operation. The caller raises `start` for one cycle with the operands and the modulus constants. Six cycles later it receives a one-cycle `done` pulse with the reduced result. Converting values into and out of the Montgomery domain, and computing the constants, is left to the surrounding logic.

Top module: `mont_mul`

## Requirements
- R1: When `start` is accepted with N odd, 1 ≤ N < 2^K, A < N, B < N and the correct constant, the `result` presented with `done` equals A·B·2^(−K) mod N and lies in [0, N).
- R2: The constant input `modNInv` must satisfy N·modNInv ≡ −1 (mod 2^K). With this constant, the sum of the operand product and the factor times the modulus has its low K bits all zero.
- R3: `start` is accepted on a rising edge while the block is idle. `done` is high for exactly one cycle, and it goes high 6 clock edges after the accepting edge.
- R4: `start` raised while an operation is in progress is ignored. The running operation finishes with its original operands, and no extra `done` pulse follows.
- R5: `result` keeps its value from one `done` pulse until the final step of the next operation.
- R6: While reset (`rstN` low) is asserted, and after its release, `done` is 0 and `result` is 0.
- R7: When the shifted sum is ≥ N, the block subtracts N exactly once. This case arises for example with A = B = N−1 and N near 2^K.
- R8: Edge moduli are handled. With N = 1 the result is 0. With N = 2^K−1 and full-width operands, the internal multiplier carries correctly through its half-width sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| opA | input | K | First residue, less than N |
| opB | input | K | Second residue, less than N |
| modN | input | K | Odd modulus |
| modNInv | input | K | Constant with N·modNInv ≡ −1 mod 2^K |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | K | A·B·2^(−K) mod N, held until the next completion |

## Verification
The bench builds the block with its default K = 32. At this width the Karatsuba multiplier splits operands into 16-bit halves and adds them in 17-bit sums, so a carry into the middle term is within reach. The intermediate sum spans 65 bits, so its top carry is exercised with moduli near 2^32. The expected values come from a bit-serial halving model, which never uses the Montgomery identity. Random odd moduli across the whole 32-bit range exercise both outcomes of the final subtraction.

// File: rtl/mont_pkg.sv
package mont_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL_AB,
    ST_MUL_M,
    ST_MUL_MN,
    ST_ADD_SHIFT,
    ST_CORRECT,
    ST_DONE
  } mont_state_e;

  typedef struct packed {
    logic load;
    logic mulAB;
    logic mulM;
    logic mulMN;
    logic addShift;
    logic correct;
  } mont_ctrl_t;

endpackage

// File: rtl/kara_mul.sv
module kara_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  generate
    if (W >= 8 && (W % 2) == 0) begin : g_kara
      localparam int H = W / 2;
      logic [H-1:0]     xh, xl, yh, yl;
      logic [H:0]       sx, sy;
      logic [2*H-1:0]   pHigh, pLow;
      logic [2*H+1:0]   pCross;
      logic [PW-1:0]    mid;

      assign xh = x[W-1:H];
      assign xl = x[H-1:0];
      assign yh = y[W-1:H];
      assign yl = y[H-1:0];
      assign sx = {1'b0, xh} + {1'b0, xl};
      assign sy = {1'b0, yh} + {1'b0, yl};

      assign pHigh  = {{H{1'b0}}, xh} * {{H{1'b0}}, yh};
      assign pLow   = {{H{1'b0}}, xl} * {{H{1'b0}}, yl};
      assign pCross = {{(H+1){1'b0}}, sx} * {{(H+1){1'b0}}, sy};

      assign mid = PW'(pCross) - PW'(pHigh) - PW'(pLow);
      assign p   = (PW'(pHigh) << W) + (mid << H) + PW'(pLow);
    end else begin : g_plain
      assign p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    end
  endgenerate

endmodule

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mont_ctrl_t ctl,
  output logic       done
);
  mont_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:      if (start) stateNext = ST_MUL_AB;
      ST_MUL_AB:    stateNext = ST_MUL_M;
      ST_MUL_M:     stateNext = ST_MUL_MN;
      ST_MUL_MN:    stateNext = ST_ADD_SHIFT;
      ST_ADD_SHIFT: stateNext = ST_CORRECT;
      ST_CORRECT:   stateNext = ST_DONE;
      ST_DONE:      stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == ST_IDLE) && start;
    ctl.mulAB    = (state == ST_MUL_AB);
    ctl.mulM     = (state == ST_MUL_M);
    ctl.mulMN    = (state == ST_MUL_MN);
    ctl.addShift = (state == ST_ADD_SHIFT);
    ctl.correct  = (state == ST_CORRECT);
  end

  assign done = (state == ST_DONE);

  // R3: completion is a single-cycle pulse
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: fixed latency from acceptance to completion
  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start) |-> ##6 done);

  // R4: a start while busy never restarts the sequence
  p_busy_ignores_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && start) |=> (state != ST_MUL_AB));

  // R1: at most one datapath step per cycle
  p_one_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl));

endmodule

// File: rtl/mont_datapath.sv
module mont_datapath
  import mont_pkg::*;
#(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mont_ctrl_t   ctl,
  input  logic [K-1:0] opA,
  input  logic [K-1:0] opB,
  input  logic [K-1:0] modN,
  input  logic [K-1:0] modNInv,
  output logic [K-1:0] result
);
  localparam int PW = 2 * K;
  localparam int SW = PW + 1;

  logic [K-1:0]  aReg, bReg, nReg, nInvReg, mReg, resReg;
  logic [PW-1:0] tReg, mnReg;
  logic [SW-1:0] sumReg;
  logic [K-1:0]  mulX, mulY;
  logic [PW-1:0] prod;
  logic [K:0]    shifted, diff;
  logic          geN;

  always_comb begin
    mulX = aReg;
    mulY = bReg;
    if (ctl.mulM) begin
      mulX = tReg[K-1:0];
      mulY = nInvReg;
    end else if (ctl.mulMN) begin
      mulX = mReg;
      mulY = nReg;
    end
  end

  kara_mul #(.W(K)) i_mul (
    .x (mulX),
    .y (mulY),
    .p (prod)
  );

  assign shifted = sumReg[SW-1:K];
  assign diff    = shifted - {1'b0, nReg};
  assign geN     = shifted >= {1'b0, nReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      nReg    <= '0;
      nInvReg <= '0;
      mReg    <= '0;
      tReg    <= '0;
      mnReg   <= '0;
      sumReg  <= '0;
      resReg  <= '0;
    end else begin
      if (ctl.load) begin
        aReg    <= opA;
        bReg    <= opB;
        nReg    <= modN;
        nInvReg <= modNInv;
      end
      if (ctl.mulAB)    tReg   <= prod;
      if (ctl.mulM)     mReg   <= prod[K-1:0];
      if (ctl.mulMN)    mnReg  <= prod;
      if (ctl.addShift) sumReg <= {1'b0, tReg} + {1'b0, mnReg};
      if (ctl.correct)  resReg <= geN ? diff[K-1:0] : shifted[K-1:0];
    end
  end

  assign result = resReg;

  // R2: the reduction leaves the low half of the sum empty
  p_low_half_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.addShift) |-> (sumReg[K-1:0] == '0));

  // R1 / R7: the corrected result is a proper residue
  p_result_below_n_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.correct) |-> (resReg < nReg));

  // R5: result only moves in the correction step
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.correct |=> $stable(resReg));

endmodule

// File: rtl/mont_mul.sv
module mont_mul
  import mont_pkg::*;
#(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [K-1:0] opA,
  input  logic [K-1:0] opB,
  input  logic [K-1:0] modN,
  input  logic [K-1:0] modNInv,
  output logic         done,
  output logic [K-1:0] result
);
  mont_ctrl_t ctl;

  mont_ctrl i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  mont_datapath #(.K(K)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opA     (opA),
    .opB     (opB),
    .modN    (modN),
    .modNInv (modNInv),
    .result  (result)
  );

endmodule

// File: tb/test_mont_mul.sv
`timescale 1ns/1ps
module test_mont_mul;
  localparam int K = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [K-1:0] opA = '0, opB = '0, modN = '0, modNInv = '0;
  logic         done;
  logic [K-1:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mont_mul #(.K(K)) i_mont_mul (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .modN(modN), .modNInv(modNInv), .done(done), .result(result)
  );

  function automatic logic [63:0] negInv(input logic [63:0] n);
    logic [63:0] inv;
    inv = n;
    for (int i = 0; i < 6; i++) inv = (inv * (64'd2 - n * inv)) & 64'hFFFF_FFFF;
    return (64'h1_0000_0000 - inv) & 64'hFFFF_FFFF;
  endfunction

  function automatic logic [63:0] refModel(input logic [63:0] a, b, n);
    logic [63:0] x;
    x = (a * b) % n;
    for (int i = 0; i < K; i++) x = x[0] ? (x + n) >> 1 : x >> 1;
    return x;
  endfunction

  task automatic check(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [63:0] a, b, n, input bit disturb, input string tag);
    int lat;
    logic [63:0] exp;
    exp = refModel(a, b, n);
    @(negedge clk);
    opA = a[K-1:0]; opB = b[K-1:0]; modN = n[K-1:0];
    modNInv = negInv(n)[K-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    // R4: second start mid-operation with different data
    if (disturb) begin
      opA = ~a[K-1:0]; opB = 1; start = 1'b1;
    end
    while (!done && lat < 20) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    check({tag, " R3 latency"}, lat, 6);
    check({tag, " R1 result"}, result, exp);
    check({tag, " R7 below N"}, result < n[K-1:0], 1);
    @(negedge clk);
    check({tag, " R3 single pulse"}, done, 0);
    repeat (8) @(negedge clk);
    if (disturb) check({tag, " R4 no extra done"}, done, 0);
    check({tag, " R5 held"}, result, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] n, a, b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R6 done in reset", done, 0);
    check("R6 result in reset", result, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R6 done after reset", done, 0);
    check("R6 result after reset", result, 0);

    runOp(64'd3, 64'd5, 64'd7, 0, "small");
    runOp(64'd0, 64'd0, 64'd1, 0, "R8 N=1");
    runOp(64'hFFFF_FFFD, 64'hFFFF_FFFD, 64'hFFFF_FFFF, 0, "R8 full width");
    runOp(64'hFFFF_FFFA, 64'hFFFF_FFF0, 64'hFFFF_FFFB, 0, "R7 near top");
    runOp(64'd0, 64'd1234, 64'd99991, 0, "zero operand");
    runOp(64'd12345, 64'd6789, 64'h8000_0001, 1, "R4 disturb");

    for (int i = 0; i < 60; i++) begin
      n = {32'd0, $urandom() | 32'd1};
      if (i % 3 == 0) n = n | 64'h8000_0000;
      a = {32'd0, $urandom()} % n;
      b = {32'd0, $urandom()} % n;
      runOp(a, b, n, (i % 10 == 0), "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule